// File: doc/BRIEF.md
# Software Store Unlock Detector

This block sits beside a 13-bit-addressed SRAM and watches the address of every completed read. A read may be a chip-enable controlled read or an output-enable controlled read; the surrounding logic turns either one into a single-cycle read strobe. When six reads land on a fixed list of addresses in strict order, with no other access in between, the block starts a nonvolatile store. It raises a one-cycle store-start pulse and asserts an I/O-disable level, which holds until the store engine reports completion.

Any read at an address that does not match the next expected step ends the current attempt, as does any write. A read of address 0x0000 that breaks a partial match counts at once as step one of a new attempt. Writes never advance the match. While the I/O-disable level is active, all read and write strobes are ignored. The erase and program timing of the store is handled elsewhere.

Top module: `sss_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, store_start and io_disable are 0, and the match progress is at step zero.
- R2: Six read strobes with addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F in that order set store_start and io_disable to 1 in the cycle after the clock edge that samples the sixth strobe. Idle cycles between the strobes are allowed.
- R3: A read strobe at an address other than the next expected one, and other than 0x0000, cancels the partial match. Reading the remaining addresses of the list afterwards does not start a store.
- R4: A write strobe at any address, including an address from the list, cancels the partial match. Writes never advance it.
- R5: A read of 0x0000 that breaks a partial match becomes step one of a new attempt, so the five remaining addresses that follow it start a store.
- R6: Only cycles with a strobe count. Address changes in cycles without a strobe have no effect on the match.
- R7: io_disable stays 1 until a cycle with store_done high. It is 0 in the cycle after the edge that samples store_done.
- R8: While io_disable is 1, read and write strobes are ignored. Addresses read during that time neither advance nor start a store, and they do not carry over once io_disable falls.
- R9: store_start is high for exactly one cycle per store. store_done while io_disable is 0 has no effect.
- R10: A read strobe and a write strobe in the same cycle count as a write, which aborts the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Address of the access marked by the strobe |
| rd_strobe | input | 1 | One-cycle pulse per completed read (chip-enable or output-enable controlled) |
| wr_strobe | input | 1 | One-cycle pulse per write |
| store_done | input | 1 | Store engine has finished |
| store_start | output | 1 | One-cycle pulse that starts the store |
| io_disable | output | 1 | Blocks SRAM access while a store runs |

## Verification
The main function is exercised with several patterns. A clean back-to-back list and a list spread out by idle cycles and floating addresses must both fire. A list broken by a foreign read, or by a write that carries a matching address, must not fire, which separates read-only advance from any-access advance. A list broken by 0x0000 and then completed from step two must fire, which separates restart from a plain abort to idle. Reads sent while the store is busy, including part of a list that is finished after store_done, must not fire. A read and a write in the same cycle show that the write wins.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int KEY_ADDR_W = 13;
  localparam int SEQ_LEN    = 6;

  // Unlock address for each step of the sequence (order is behaviour).
  function automatic logic [KEY_ADDR_W-1:0] key_addr(input int idx);
    case (idx)
      0:       key_addr = 13'h0000;
      1:       key_addr = 13'h1555;
      2:       key_addr = 13'h0AAA;
      3:       key_addr = 13'h1FFF;
      4:       key_addr = 13'h10F0;
      default: key_addr = 13'h0F0F;
    endcase
  endfunction
endpackage

// File: rtl/sss_key_match.sv
module sss_key_match #(
  parameter int ADDR_W = sss_pkg::KEY_ADDR_W,
  parameter int STEPS  = sss_pkg::SEQ_LEN,
  localparam int CNT_W = $clog2(STEPS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  step,
  output logic              hit_step,
  output logic              hit_first,
  output logic              last_step
);
  logic [ADDR_W-1:0] key_tab [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_key
    assign key_tab[i] = ADDR_W'(sss_pkg::key_addr(i));
  end

  assign hit_step  = (addr == key_tab[step]);
  assign hit_first = (addr == key_tab[0]);
  assign last_step = (step == CNT_W'(STEPS - 1));
endmodule

// File: rtl/sss_step_ctr.sv
module sss_step_ctr #(
  parameter int STEPS  = sss_pkg::SEQ_LEN,
  localparam int CNT_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             restart,
  output logic [CNT_W-1:0] step
);
  always_ff @(posedge clk) begin
    if (rst || clr)   step <= '0;
    else if (adv)     step <= step + CNT_W'(1);
    else if (restart) step <= CNT_W'(1);
  end
endmodule

// File: rtl/sss_busy_ctl.sv
module sss_busy_ctl (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic done,
  output logic store_start,
  output logic io_disable
);
  always_ff @(posedge clk) begin
    if (rst) begin
      store_start <= 1'b0;
      io_disable  <= 1'b0;
    end else begin
      store_start <= fire;
      if (fire)      io_disable <= 1'b1;
      else if (done) io_disable <= 1'b0;
    end
  end
endmodule

// File: rtl/sss_detector.sv
module sss_detector #(
  parameter int ADDR_W = sss_pkg::KEY_ADDR_W,
  parameter int STEPS  = sss_pkg::SEQ_LEN,
  localparam int CNT_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_strobe,
  input  logic              wr_strobe,
  input  logic              store_done,
  output logic              store_start,
  output logic              io_disable
);
  logic [CNT_W-1:0] step;
  logic hit_step, hit_first, last_step;
  logic rd_ok, wr_ok, fire, adv, restart, clr;

  // Strobes count only while no store is running; a write beats a read.
  assign rd_ok   = rd_strobe & ~wr_strobe & ~io_disable;
  assign wr_ok   = wr_strobe & ~io_disable;
  assign fire    = rd_ok & hit_step & last_step;
  assign adv     = rd_ok & hit_step & ~last_step;
  assign restart = rd_ok & ~hit_step & hit_first;
  assign clr     = wr_ok | fire | (rd_ok & ~hit_step & ~hit_first);

  sss_key_match #(.ADDR_W(ADDR_W), .STEPS(STEPS)) u_match (
    .addr(addr), .step(step), .hit_step(hit_step),
    .hit_first(hit_first), .last_step(last_step)
  );

  sss_step_ctr #(.STEPS(STEPS)) u_ctr (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv),
    .restart(restart), .step(step)
  );

  sss_busy_ctl u_busy (
    .clk(clk), .rst(rst), .fire(fire), .done(store_done),
    .store_start(store_start), .io_disable(io_disable)
  );
endmodule

// File: rtl/sss_detector_chk.sv
module sss_detector_chk (
  input logic clk,
  input logic rst,
  input logic rd_strobe,
  input logic wr_strobe,
  input logic store_done,
  input logic store_start,
  input logic io_disable
);
  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    store_start |=> !store_start);

  // R2
  start_with_disable_chk: assert property (@(posedge clk) disable iff (rst)
    store_start |-> io_disable);

  // R7
  disable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_disable && !store_done) |=> io_disable);

  // R7
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (io_disable && store_done) |=> !io_disable);

  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    io_disable |=> !store_start);

  // R10
  rise_from_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(io_disable) |-> ($past(rd_strobe) && !$past(wr_strobe)));
endmodule

bind sss_detector sss_detector_chk u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
  .store_done(store_done), .store_start(store_start), .io_disable(io_disable)
);

// File: tb/tb_sss_detector.sv
`timescale 1ns/1ps
module tb_sss_detector;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] addr;
  logic        rd_strobe, wr_strobe, store_done;
  logic        store_start, io_disable;

  int errors = 0;
  int checks = 0;
  bit ended  = 0;
  bit fired;

  localparam logic [12:0] K0 = 13'h0000, K1 = 13'h1555, K2 = 13'h0AAA,
                          K3 = 13'h1FFF, K4 = 13'h10F0, K5 = 13'h0F0F;

  always #4 clk = ~clk;

  sss_detector dut (
    .clk(clk), .rst(rst), .addr(addr), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .store_done(store_done),
    .store_start(store_start), .io_disable(io_disable)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One strobed access; sampled on the next falling edge, after the sampling edge.
  task automatic access(input logic [12:0] a, input logic rd, input logic wr);
    @(negedge clk);
    addr = a; rd_strobe = rd; wr_strobe = wr;
    @(negedge clk);
    rd_strobe = 1'b0; wr_strobe = 1'b0;
    if (store_start) fired = 1'b1;
  endtask

  task automatic rd(input logic [12:0] a); access(a, 1'b1, 1'b0); endtask
  task automatic wr(input logic [12:0] a); access(a, 1'b0, 1'b1); endtask

  task automatic finish_store();
    @(negedge clk); store_done = 1'b1;
    @(negedge clk); store_done = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 start in reset", store_start, 1'b0);
    check("R1 disable in reset", io_disable, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 start after reset", store_start, 1'b0);
    check("R1 disable after reset", io_disable, 1'b0);
  endtask

  task automatic t_full();
    fired = 0;
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4);
    check("R2 no start before sixth", fired, 1'b0);
    rd(K5);
    check("R2 start pulse", store_start, 1'b1);
    check("R2 disable set", io_disable, 1'b1);
    @(negedge clk);
    check("R9 pulse one cycle", store_start, 1'b0);
    repeat (5) @(negedge clk);
    check("R7 disable held", io_disable, 1'b1);
    finish_store();
    check("R7 disable cleared", io_disable, 1'b0);
  endtask

  task automatic t_wrong_addr();
    fired = 0;
    rd(K0); rd(K1); rd(13'h0123); rd(K2); rd(K3); rd(K4); rd(K5);
    check("R3 foreign read aborts", fired, 1'b0);
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(13'h0F0E);
    rd(K5);
    check("R3 wrong sixth aborts", fired, 1'b0);
    check("R3 disable stays low", io_disable, 1'b0);
  endtask

  task automatic t_write_abort();
    fired = 0;
    rd(K0); rd(K1); rd(K2); wr(K3); rd(K3); rd(K4); rd(K5);
    check("R4 write aborts", fired, 1'b0);
    rd(K0); wr(K1); rd(K2); rd(K3); rd(K4); rd(K5);
    check("R4 write does not advance", fired, 1'b0);
    check("R4 disable stays low", io_disable, 1'b0);
  endtask

  task automatic t_restart();
    fired = 0;
    rd(K0); rd(K1); rd(K2); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(K5);
    check("R5 restart at step one", fired, 1'b1);
    check("R5 disable set", io_disable, 1'b1);
    finish_store();
  endtask

  task automatic t_gaps();
    fired = 0;
    rd(K0);
    @(negedge clk); addr = 13'h0777;
    rd(K1);
    repeat (3) @(negedge clk); addr = 13'h1234;
    rd(K2); rd(K3);
    @(negedge clk); addr = K0;
    @(negedge clk);
    rd(K4); rd(K5);
    check("R6 idle gaps ignored", fired, 1'b1);
    finish_store();
    check("R6 disable cleared", io_disable, 1'b0);
  endtask

  task automatic t_busy();
    fired = 0;
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(K5);
    check("R8 store started", io_disable, 1'b1);
    fired = 0;
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(K5);
    check("R8 reads ignored when busy", fired, 1'b0);
    rd(K0); rd(K1); rd(K2);
    finish_store();
    rd(K3); rd(K4); rd(K5);
    check("R8 no carry-over", fired, 1'b0);
    check("R8 disable low", io_disable, 1'b0);
    finish_store();
    check("R9 idle done no effect", io_disable, 1'b0);
    check("R9 idle done no start", store_start, 1'b0);
  endtask

  task automatic t_simult();
    fired = 0;
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4);
    access(K5, 1'b1, 1'b1);
    check("R10 read+write no start", fired, 1'b0);
    rd(K5);
    check("R10 write aborted", fired, 1'b0);
    check("R10 disable low", io_disable, 1'b0);
  endtask

  initial begin
    rst = 1'b1; addr = '0; rd_strobe = 0; wr_strobe = 0; store_done = 0;
    t_reset();
    t_full();
    t_wrong_addr();
    t_write_abort();
    t_restart();
    t_gaps();
    t_busy();
    t_simult();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule